// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns the indexed-mode postbyte of a small 8-bit controller with a 16-bit address space into an effective address. A caller pulses `start` with the postbyte, the current index registers (X, Y, stack pointer, program counter) and the two 8-bit accumulators. The block takes a copy of all of these at that edge, decodes the postbyte, and either answers in the next cycle or walks a short sequence. That sequence can pull one or two extension bytes from the instruction stream through a request/acknowledge fetch port, and can read a 16-bit pointer through a request/acknowledge memory port.

The postbyte chooses among these forms: a 5-bit signed constant, auto increment or decrement applied before or after use, 9-bit and 16-bit constant offsets, accumulator offsets, and two memory-indirect forms. The auto-modify forms return the new index value on a one-cycle write-back strobe. The final address comes with a one-cycle `done` pulse and an `extra_cycle` flag that tells the sequencer whether the form costs one more bus cycle. When `restrict_en` is high, the offset and indirect forms are refused: they return address zero and touch neither port.

Top module: `idx_addr_gen`

## Requirements
- R1: With postbyte bit 5 clear, the address is base + sign-extended bits 4:0 (range -16..+15). Bits 7:6 pick the base: 0=X, 1=Y, 2=SP, 3=PC. extra_cycle is 0 and no fetch or memory read occurs.
- R2: With bit 5 set and bits 7:6 not 11 (auto-modify), the step is computed from the low nibble. If bit 3 is set, the nibble is sign-extended (-8..-1). If bit 3 is clear, the step is nibble+1 (+1..+8). The base is picked by bits 7:6 as in R1. wb_valid pulses together with done, with wb_sel = bits 7:6 and wb_data = base + step. extra_cycle is 0.
- R3: In auto-modify, bit 4 = 0 gives the updated value as the address (pre-modify). Bit 4 = 1 gives the original base as the address (post-modify).
- R4: With bits 7:5 = 111, bit 2 = 0, bit 1 = 0 (and not the R6 code), exactly one byte is fetched. Bit 0 supplies the upper 8 offset bits (0x00 or 0xFF). The base is picked by bits 4:3 (0=X, 1=Y, 2=SP, 3=PC). extra_cycle is 1.
- R5: With bits 7:5 = 111, bit 2 = 0 and bits 1:0 = 10, two bytes are fetched, most significant first. The address is base (bits 4:3) + that 16-bit offset, and extra_cycle is 1.
- R6: With bits 7:5 = 111 and bits 2:0 = 011, two offset bytes are fetched, MSB first. A 16-bit read is then issued at base + offset. The address is the returned word and extra_cycle is 1. mem_addr is held steady until mem_ack.
- R7: With bits 7:5 = 111, bit 2 = 1 and bits 1:0 = 00, 01 or 10, the base (bits 4:3) is added to zero-extended A, zero-extended B, or D = {A,B}. extra_cycle is 0 and neither port is used.
- R8: With bits 7:5 = 111 and bits 2:0 = 111, a 16-bit read is issued at base + D. The address is the returned word and extra_cycle is 1.
- R9: With restrict_en high, the R4, R5, R6 and R8 forms return address 0 with extra_cycle 0 in the cycle after start, and use neither port. The R1, R2 and R7 forms are unaffected.
- R10: done is high in the cycle after the last handshake edge, or in the cycle after start for forms that need no handshake. A request stays high with its address stable until acknowledged.
- R11: Register and accumulator inputs are sampled only at an accepted start. A start while busy is ignored and produces no extra done.
- R12: After reset, done, wb_valid, fetch_req, mem_req and busy are low.
- R13: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decode of `postbyte` (ignored while busy) |
| postbyte | input | 8 | Indexed-mode postbyte |
| restrict_en | input | 1 | Refuse offset and indirect forms |
| x_reg | input | 16 | Index register X |
| y_reg | input | 16 | Index register Y |
| sp_reg | input | 16 | Stack pointer |
| pc_reg | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| wb_valid | output | 1 | Index write-back strobe |
| wb_sel | output | 2 | Register written: 0=X, 1=Y, 2=SP, 3=PC |
| wb_data | output | 16 | New index value |
| fetch_req | output | 1 | Extension byte wanted |
| fetch_ack | input | 1 | Byte on `fetch_byte` is valid this cycle |
| fetch_byte | input | 8 | Extension byte |
| mem_req | output | 1 | 16-bit pointer read wanted |
| mem_addr | output | 16 | Pointer read address |
| mem_ack | input | 1 | `mem_rdata` is valid this cycle |
| mem_rdata | input | 16 | Pointer word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | `ea` and `extra_cycle` are valid |
| ea | output | 16 | Effective address |
| extra_cycle | output | 1 | Form costs one additional cycle |

## Verification
The bench builds the block with its default byte width of 8, giving 16-bit addresses and D as {A,B}. With that width a wrap past 0xFFFF can be reached in one offset addition, and every postbyte family can be driven with hand-computed results. The whole vector table is applied twice: once with handshakes acknowledged at once, and once with two-cycle stalls on every request. This exercises held requests and the latency rule for each form.

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      postbyte,
  input  logic            restrict_en,
  input  logic [2*BW-1:0] x_reg,
  input  logic [2*BW-1:0] y_reg,
  input  logic [2*BW-1:0] sp_reg,
  input  logic [2*BW-1:0] pc_reg,
  input  logic [BW-1:0]   acc_a,
  input  logic [BW-1:0]   acc_b,
  output logic            wb_valid,
  output logic [1:0]      wb_sel,
  output logic [2*BW-1:0] wb_data,
  output logic            fetch_req,
  input  logic            fetch_ack,
  input  logic [BW-1:0]   fetch_byte,
  output logic            mem_req,
  output logic [2*BW-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [2*BW-1:0] mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [2*BW-1:0] ea,
  output logic            extra_cycle
);
  localparam int AW = 2 * BW;

  typedef enum logic [1:0] {S_IDLE, S_FHI, S_FLO, S_MEM} st_t;
  st_t st;

  logic [2:0]    pb_q;
  logic [AW-1:0] base_q;
  logic [BW-1:0] hi_q;

  logic [AW-1:0] base_short, base_ext;
  always_comb begin
    case (postbyte[7:6])
      2'd0:    base_short = x_reg;
      2'd1:    base_short = y_reg;
      2'd2:    base_short = sp_reg;
      default: base_short = pc_reg;
    endcase
    case (postbyte[4:3])
      2'd0:    base_ext = x_reg;
      2'd1:    base_ext = y_reg;
      2'd2:    base_ext = sp_reg;
      default: base_ext = pc_reg;
    endcase
  end

  wire grp     = (postbyte[7:5] == 3'b111);
  wire f_short = ~postbyte[5];
  wire f_auto  = postbyte[5] & (postbyte[7:6] != 2'b11);
  wire f_ind16 = grp & (postbyte[2:0] == 3'b011);
  wire f_cofs  = grp & ~postbyte[2] & ~f_ind16;
  wire f_acc   = grp & postbyte[2];
  wire f_dind  = f_acc & (postbyte[1:0] == 2'b11);
  wire f_refuse = restrict_en & (f_ind16 | f_cofs | f_dind);

  wire [AW-1:0] short_off = {{(AW-5){postbyte[4]}}, postbyte[4:0]};
  wire [AW-1:0] auto_off  = postbyte[3] ? {{(AW-4){1'b1}}, postbyte[3:0]}
                                        : {{(AW-4){1'b0}}, postbyte[3:0]} + AW'(1);
  wire [AW-1:0] auto_new  = base_short + auto_off;

  logic [AW-1:0] acc_off;
  always_comb begin
    case (postbyte[1:0])
      2'd0:    acc_off = {{BW{1'b0}}, acc_a};
      2'd1:    acc_off = {{BW{1'b0}}, acc_b};
      default: acc_off = {acc_a, acc_b};
    endcase
  end
  wire [AW-1:0] acc_sum = base_ext + acc_off;

  wire [AW-1:0] ext_off = pb_q[1] ? {hi_q, fetch_byte} : {{BW{pb_q[0]}}, fetch_byte};
  wire [AW-1:0] ext_sum = base_q + ext_off;

  assign fetch_req = (st == S_FHI) || (st == S_FLO);
  assign mem_req   = (st == S_MEM);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pb_q        <= '0;
      base_q      <= '0;
      hi_q        <= '0;
      done        <= 1'b0;
      ea          <= '0;
      extra_cycle <= 1'b0;
      wb_valid    <= 1'b0;
      wb_sel      <= '0;
      wb_data     <= '0;
      mem_addr    <= '0;
    end else begin
      done     <= 1'b0;
      wb_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pb_q   <= postbyte[2:0];
          base_q <= base_ext;
          if (f_refuse) begin
            done <= 1'b1; ea <= '0; extra_cycle <= 1'b0;
          end else if (f_short) begin
            done <= 1'b1; ea <= base_short + short_off; extra_cycle <= 1'b0;
          end else if (f_auto) begin
            done        <= 1'b1;
            ea          <= postbyte[4] ? base_short : auto_new;
            extra_cycle <= 1'b0;
            wb_valid    <= 1'b1;
            wb_sel      <= postbyte[7:6];
            wb_data     <= auto_new;
          end else if (f_dind) begin
            mem_addr <= acc_sum;
            st       <= S_MEM;
          end else if (f_acc) begin
            done <= 1'b1; ea <= acc_sum; extra_cycle <= 1'b0;
          end else if (postbyte[1]) begin
            st <= S_FHI;
          end else begin
            st <= S_FLO;
          end
        end
        S_FHI: if (fetch_ack) begin
          hi_q <= fetch_byte;
          st   <= S_FLO;
        end
        S_FLO: if (fetch_ack) begin
          if (pb_q == 3'b011) begin
            mem_addr <= ext_sum;
            st       <= S_MEM;
          end else begin
            done <= 1'b1; ea <= ext_sum; extra_cycle <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: if (mem_ack) begin
          done <= 1'b1; ea <= mem_rdata; extra_cycle <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            extra_cycle,
  input logic            wb_valid,
  input logic            fetch_req,
  input logic            fetch_ack,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [2*BW-1:0] mem_addr
);
  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, mem_req, done}));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> fetch_req);

  // R2
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (done && !extra_cycle));
endmodule

bind idx_addr_gen idx_addr_gen_chk #(.BW(BW)) chk_i (.*);

// File: tb/idx_addr_gen_tb_top.sv
module idx_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, restrict_en = 1'b0;
  logic [7:0]  postbyte = '0;
  logic [15:0] x_reg = 16'h1000, y_reg = 16'h2000, sp_reg = 16'h3000, pc_reg = 16'h4000;
  logic [7:0]  acc_a = 8'h80, acc_b = 8'h05;
  logic        wb_valid, fetch_req, mem_req, busy, done, extra_cycle;
  logic [1:0]  wb_sel;
  logic [15:0] wb_data, mem_addr, ea;
  logic        fetch_ack = 1'b0, mem_ack = 1'b0;
  logic [7:0]  fetch_byte = '0;
  logic [15:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte), .restrict_en(restrict_en),
    .x_reg(x_reg), .y_reg(y_reg), .sp_reg(sp_reg), .pc_reg(pc_reg), .acc_a(acc_a), .acc_b(acc_b),
    .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_byte(fetch_byte),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea(ea), .extra_cycle(extra_cycle));

  typedef struct packed {
    logic [3:0]  rq;
    logic [7:0]  pb;
    logic        rs;
    logic [7:0]  b0, b1;
    logic [15:0] mrd;
    logic [15:0] ea;
    logic        xc;
    logic        wb;
    logic [1:0]  wsel;
    logic [15:0] wbd;
    logic [1:0]  nf;
    logic        mem;
    logic [15:0] maddr;
  } vec_t;

  localparam int NV = 25;
  // X=1000 Y=2000 SP=3000 PC=4000 A=80 B=05
  localparam vec_t VECS [NV] = '{
    '{4'd1,  8'h05, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h1005, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R1 X+5
    '{4'd1,  8'h50, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h1FF0, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R1 Y-16
    '{4'd1,  8'h8F, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h300F, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R1 SP+15
    '{4'd1,  8'hDF, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h3FFF, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R1 PC-1
    '{4'd3,  8'h23, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h1004, 1'b0, 1'b1, 2'd0, 16'h1004, 2'd0, 1'b0, 16'h0000}, // R2 R3 pre +4 X
    '{4'd3,  8'h78, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h2000, 1'b0, 1'b1, 2'd1, 16'h1FF8, 2'd0, 1'b0, 16'h0000}, // R2 R3 post -8 Y
    '{4'd2,  8'hAF, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h2FFF, 1'b0, 1'b1, 2'd2, 16'h2FFF, 2'd0, 1'b0, 16'h0000}, // R2 pre -1 SP
    '{4'd2,  8'hB7, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h3000, 1'b0, 1'b1, 2'd2, 16'h3008, 2'd0, 1'b0, 16'h0000}, // R2 post +8 SP
    '{4'd4,  8'hE0, 1'b0, 8'h7F, 8'h00, 16'h0000, 16'h107F, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd1, 1'b0, 16'h0000}, // R4 X+7F
    '{4'd4,  8'hE9, 1'b0, 8'h10, 8'h00, 16'h0000, 16'h1F10, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd1, 1'b0, 16'h0000}, // R4 Y+FF10
    '{4'd5,  8'hF2, 1'b0, 8'h12, 8'h34, 16'h0000, 16'h4234, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd2, 1'b0, 16'h0000}, // R5 SP+1234
    '{4'd13, 8'hFA, 1'b0, 8'hC0, 8'h01, 16'h0000, 16'h0001, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd2, 1'b0, 16'h0000}, // R13 R5 PC+C001 wraps
    '{4'd6,  8'hE3, 1'b0, 8'h00, 8'h20, 16'hBEEF, 16'hBEEF, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd2, 1'b1, 16'h1020}, // R6 [X+0020]
    '{4'd6,  8'hEB, 1'b0, 8'hFF, 8'hFE, 16'h5A5A, 16'h5A5A, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd2, 1'b1, 16'h1FFE}, // R6 [Y-2] wraps
    '{4'd7,  8'hE4, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h1080, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R7 X+A
    '{4'd7,  8'hF5, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h3005, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R7 SP+B
    '{4'd7,  8'hEE, 1'b0, 8'h00, 8'h00, 16'h0000, 16'hA005, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R7 Y+D
    '{4'd8,  8'hFF, 1'b0, 8'h00, 8'h00, 16'h1357, 16'h1357, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b1, 16'hC005}, // R8 [PC+D]
    '{4'd9,  8'hE0, 1'b1, 8'h00, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R9 9-bit refused
    '{4'd9,  8'hF2, 1'b1, 8'h00, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R9 16-bit refused
    '{4'd9,  8'hE3, 1'b1, 8'h00, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R9 indirect refused
    '{4'd9,  8'hFF, 1'b1, 8'h00, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R9 D-indirect refused
    '{4'd9,  8'h05, 1'b1, 8'h00, 8'h00, 16'h0000, 16'h1005, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}, // R9 short allowed
    '{4'd9,  8'h23, 1'b1, 8'h00, 8'h00, 16'h0000, 16'h1004, 1'b0, 1'b1, 2'd0, 16'h1004, 2'd0, 1'b0, 16'h0000}, // R9 auto allowed
    '{4'd9,  8'hE4, 1'b1, 8'h00, 8'h00, 16'h0000, 16'h1080, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0000}  // R9 acc allowed
  };

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int stall);
    int fcnt = 0, lat = 0, wait_s = stall;
    bit got = 0, memseen = 0, wbseen = 0;
    logic [15:0] maddr = '0, ea_s = '0, wbd_s = '0;
    logic [1:0]  wsel_s = '0;
    logic        xc_s = 1'b0;
    @(negedge clk);
    postbyte = v.pb; restrict_en = v.rs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40 && !got; c++) begin
      fetch_ack = 1'b0; mem_ack = 1'b0;
      if (done) begin
        got = 1; lat = c; ea_s = ea; xc_s = extra_cycle;
        if (wb_valid) begin wbseen = 1; wsel_s = wb_sel; wbd_s = wb_data; end
      end else begin
        if (fetch_req) begin
          if (wait_s > 0) wait_s--;
          else begin
            fetch_ack = 1'b1; fetch_byte = (fcnt == 0) ? v.b0 : v.b1;
            fcnt++; wait_s = stall;
          end
        end
        if (mem_req) begin
          memseen = 1; maddr = mem_addr;
          if (wait_s > 0) wait_s--;
          else begin mem_ack = 1'b1; mem_rdata = v.mrd; wait_s = stall; end
        end
        @(negedge clk);
      end
    end
    fetch_ack = 1'b0; mem_ack = 1'b0;
    chk(got, "done seen", v.rq, 32'(got), 32'd1);
    chk(ea_s == v.ea, $sformatf("ea pb=%h", v.pb), v.rq, 32'(ea_s), 32'(v.ea));
    chk(xc_s == v.xc, $sformatf("extra_cycle pb=%h", v.pb), v.rq, 32'(xc_s), 32'(v.xc));
    chk(wbseen == v.wb, $sformatf("write-back presence pb=%h", v.pb), v.rq, 32'(wbseen), 32'(v.wb));
    if (v.wb) begin
      chk(wsel_s == v.wsel, "wb_sel", v.rq, 32'(wsel_s), 32'(v.wsel));
      chk(wbd_s == v.wbd, "wb_data", v.rq, 32'(wbd_s), 32'(v.wbd));
    end
    chk(fcnt == int'(v.nf), $sformatf("fetch count pb=%h", v.pb), v.rq, 32'(fcnt), 32'(v.nf));
    chk(memseen == v.mem, $sformatf("memory read presence pb=%h", v.pb), v.rq, 32'(memseen), 32'(v.mem));
    if (v.mem) chk(maddr == v.maddr, "mem_addr", v.rq, 32'(maddr), 32'(v.maddr));
    // R10 latency: each handshake costs stall+1 cycles
    chk(lat == (int'(v.nf) + int'(v.mem)) * (stall + 1), $sformatf("R10 latency pb=%h", v.pb), 10,
        32'(lat), 32'((int'(v.nf) + int'(v.mem)) * (stall + 1)));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int dones;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!done && !wb_valid && !fetch_req && !mem_req && !busy, "R12 outputs in reset", 12,
        {27'd0, done, wb_valid, fetch_req, mem_req, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !fetch_req && !mem_req && !busy, "R12 idle after reset", 12,
        {28'd0, done, fetch_req, mem_req, busy}, 32'd0);

    for (int s = 0; s <= 2; s += 2)
      for (int i = 0; i < NV; i++) run_vec(VECS[i], s);

    // R11 snapshot and start-while-busy ignored
    @(negedge clk);
    postbyte = 8'hE0; restrict_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fetch_req, "R11 fetch requested", 11, 32'(fetch_req), 32'd1);
    x_reg = 16'h5555; postbyte = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && fetch_req, "R11 start while busy ignored", 11, {30'd0, done, fetch_req}, 32'd1);
    fetch_ack = 1'b1; fetch_byte = 8'h7F;
    @(negedge clk);
    fetch_ack = 1'b0;
    chk(done && ea == 16'h107F, "R11 address uses sampled X", 11, 32'(ea), 32'h107F);
    dones = 0;
    for (int c = 0; c < 4; c++) begin @(negedge clk); if (done) dones++; end
    chk(dones == 0, "R11 no extra done", 11, 32'(dones), 32'd0);
    x_reg = 16'h1000;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule